// File: doc/BRIEF.md
# Return-Address Stack with Fill-Level Interrupt

This block keeps return addresses for a processor core in a last-in, first-out store of 33 entries. The core pushes a return address on a call and pops it on a return. The entry on top is always visible on a dedicated output. The block keeps a count of occupied entries and drives full and empty flags from that count.

Software is warned early when the stack comes close to overflow or underflow. When the enable input is high, a level interrupt request is raised while fewer than three entries are held or while more than twenty-eight are held. The handler can then spill entries to memory or refill them before an overflow or underflow happens. The block does not stall the core. A push while full or a pop while empty is dropped, and it sets a sticky error flag that only reset clears.

The push and pop strobes have no ready signal, so there is no back-pressure. Every strobe is acted on, or dropped and flagged, in the cycle it is presented.

Top module: `ret_stack`

## Requirements
- R1: After reset the count is 0, `empty_o` is 1, `full_o` is 0, both error flags are 0 and `top_o` is 0.
- R2: A push alone on a stack that is not full stores `push_data_i` above the old top. After the same clock edge the count is one higher and `top_o` shows the pushed value.
- R3: A pop alone on a stack that is not empty removes the top entry. After that edge the count is one lower and `top_o` shows the entry pushed before it, or 0 when the stack is empty.
- R4: Push and pop together on a stack that is not empty replace the top entry with `push_data_i` and leave the count unchanged. Together on an empty stack, the push is stored (count becomes 1) and the pop sets the underflow flag.
- R5: A push alone while the count is 33 is ignored: the count and `top_o` stay as they were, and `ovf_o` is set.
- R6: A pop alone while the count is 0 is ignored: the count stays 0, and `unf_o` is set.
- R7: `full_o` is 1 exactly when the count is 33, and `empty_o` is 1 exactly when the count is 0. The count never exceeds 33.
- R8: With `lvl_irq_en_i` at 1, `lvl_irq_o` is 1 while the count is 0, 1 or 2.
- R9: With `lvl_irq_en_i` at 1, `lvl_irq_o` is 1 while the count is 29 to 33.
- R10: `lvl_irq_o` is 0 while `lvl_irq_en_i` is 0, and also while the count is 3 to 28. The output follows the enable in the same cycle, with no clock edge between.
- R11: `ovf_o` and `unf_o` stay at 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| push_data_i | input | 16 | Return address to push |
| lvl_irq_en_i | input | 1 | Enable for the fill-level interrupt |
| top_o | output | 16 | Entry on top of the stack, 0 when empty |
| count_o | output | 6 | Number of occupied entries, 0 to 33 |
| full_o | output | 1 | Count equals 33 |
| empty_o | output | 1 | Count equals 0 |
| ovf_o | output | 1 | Sticky flag: a push was dropped |
| unf_o | output | 1 | Sticky flag: a pop was dropped |
| lvl_irq_o | output | 1 | Fill-level interrupt request |

## Verification
Push and pop can arrive in the same cycle. That case is judged at both boundaries: on a full stack it must replace the top without raising overflow, and on an empty stack it must store the entry while raising underflow. The random phases drive both strobes independently, with the push rate biased first high and then low, so the stack sweeps between empty and full and meets both boundaries many times. Directed steps force the simultaneous case at count 0 and at count 33. A bench model predicts the count, the top entry, the flags and the interrupt level after every edge, and each output is compared with that prediction.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_SWAP,
    OP_SWAP_EMPTY,
    OP_BAD_PUSH,
    OP_BAD_POP
  } rs_op_e;
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
#(
  parameter int DEPTH = 33,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             wr_en_o,
  output logic [CNT_W-1:0] wr_idx_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d, unf_q, unf_d;
  rs_op_e           op;

  assign full_o  = (cnt_q == DEPTH_C);
  assign empty_o = (cnt_q == '0);

  always_comb begin
    unique case ({push_i, pop_i})
      2'b10:   op = full_o  ? OP_BAD_PUSH   : OP_PUSH;
      2'b01:   op = empty_o ? OP_BAD_POP    : OP_POP;
      2'b11:   op = empty_o ? OP_SWAP_EMPTY : OP_SWAP;
      default: op = OP_IDLE;
    endcase
  end

  always_comb begin
    cnt_d    = cnt_q;
    ovf_d    = ovf_q;
    unf_d    = unf_q;
    wr_en_o  = 1'b0;
    wr_idx_o = cnt_q;
    unique case (op)
      OP_PUSH: begin
        wr_en_o = 1'b1;
        cnt_d   = cnt_q + ONE_C;
      end
      OP_POP: cnt_d = cnt_q - ONE_C;
      OP_SWAP: begin
        wr_en_o  = 1'b1;
        wr_idx_o = cnt_q - ONE_C;
      end
      OP_SWAP_EMPTY: begin
        wr_en_o  = 1'b1;
        wr_idx_o = '0;
        cnt_d    = ONE_C;
        unf_d    = 1'b1;
      end
      OP_BAD_PUSH: ovf_d = 1'b1;
      OP_BAD_POP:  unf_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH_C);
  p_push_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> (cnt_q == $past(cnt_q) + ONE_C));
  p_pop_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o) |=> (cnt_q == $past(cnt_q) - ONE_C));
  p_swap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !empty_o) |=> $stable(cnt_q));
  p_full_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> (cnt_q == DEPTH_C) && ovf_q);
  p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> (cnt_q == '0) && unf_q);
  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  p_unf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q |=> unf_q);
endmodule

// File: rtl/rs_store.sv
module rs_store #(
  parameter int DEPTH  = 33,
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] top_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[g] <= '0;
      else if (wr_en_i && (wr_idx_i == CNT_W'(g)))
        mem_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (count_i == CNT_W'(i + 1)) top_o = mem_q[i];
  end

  p_wr_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> (wr_idx_i < CNT_W'(DEPTH)));
endmodule

// File: rtl/rs_watermark.sv
module rs_watermark #(
  parameter int DEPTH     = 33,
  parameter int LOW_MARK  = 3,
  parameter int HIGH_MARK = 28,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic             en_i,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] LOW_C  = CNT_W'(LOW_MARK);
  localparam logic [CNT_W-1:0] HIGH_C = CNT_W'(HIGH_MARK);

  logic below, above;
  assign below = (count_i < LOW_C);
  assign above = (count_i > HIGH_C);
  assign irq_o = en_i && (below || above);

  always_comb begin
    if (below && above) $display("watermark regions overlap: R8/R9 marks misordered");
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 33,
  parameter int LOW_MARK  = 3,
  parameter int HIGH_MARK = 28,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              lvl_irq_en_i,
  output logic [DATA_W-1:0] top_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              ovf_o,
  output logic              unf_o,
  output logic              lvl_irq_o
);
  logic             wr_en;
  logic [CNT_W-1:0] wr_idx;

  rs_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .count_o(count_o), .full_o(full_o), .empty_o(empty_o),
    .ovf_o(ovf_o), .unf_o(unf_o), .wr_en_o(wr_en), .wr_idx_o(wr_idx)
  );

  rs_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(push_data_i), .count_i(count_o), .top_o(top_o)
  );

  rs_watermark #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK),
                 .CNT_W(CNT_W)) u_mark (
    .count_i(count_o), .en_i(lvl_irq_en_i), .irq_o(lvl_irq_o)
  );

  p_top_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> (top_o == $past(push_data_i)));
  p_top_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> (top_o == $past(push_data_i)));
  p_top_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> $stable(top_o));
  p_irq_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && lvl_irq_en_i) |-> lvl_irq_o);
  p_irq_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && lvl_irq_en_i) |-> lvl_irq_o);
  p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_irq_en_i |-> !lvl_irq_o);
endmodule

// File: tb/ret_stack_test.sv
`timescale 1ns/1ps
module ret_stack_test;
  localparam int DW = 16;
  localparam int DEPTH = 33;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push = 1'b0, pop = 1'b0, en = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] top;
  logic [5:0]    count;
  logic          full, empty, ovf, unf, irq;

  int total = 0;
  int bad = 0;

  logic [DW-1:0] m_mem [DEPTH];
  int            m_cnt = 0;
  logic          m_ovf = 1'b0, m_unf = 1'b0;

  always #4 clk = ~clk;

  ret_stack uut (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .push_data_i(din),
    .lvl_irq_en_i(en), .top_o(top), .count_o(count), .full_o(full),
    .empty_o(empty), .ovf_o(ovf), .unf_o(unf), .lvl_irq_o(irq)
  );

  function automatic logic exp_irq(int c, logic e);
    return e && (c < 3 || c > 28);
  endfunction

  function automatic logic [DW-1:0] exp_top();
    return (m_cnt == 0) ? '0 : m_mem[m_cnt-1];
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    string ir;
    chk(req, "count", int'(count), m_cnt);
    chk(req, "top", int'(top), int'(exp_top()));
    chk("R7", "full", int'(full), int'(m_cnt == DEPTH));
    chk("R7", "empty", int'(empty), int'(m_cnt == 0));
    chk("R11", "ovf", int'(ovf), int'(m_ovf));
    chk("R11", "unf", int'(unf), int'(m_unf));
    if (!en || (m_cnt >= 3 && m_cnt <= 28)) ir = "R10";
    else if (m_cnt < 3) ir = "R8";
    else ir = "R9";
    chk(ir, "irq", int'(irq), int'(exp_irq(m_cnt, en)));
  endtask

  // one clock step; inputs applied at a falling edge, outputs checked at the next
  task automatic step(logic p, logic q, logic [DW-1:0] d, logic e);
    string req;
    push = p; pop = q; din = d; en = e;
    @(posedge clk);
    req = "R1";
    if (p && q) begin
      req = "R4";
      if (m_cnt > 0) m_mem[m_cnt-1] = d;
      else begin m_mem[0] = d; m_cnt = 1; m_unf = 1'b1; end
    end else if (p) begin
      if (m_cnt == DEPTH) begin m_ovf = 1'b1; req = "R5"; end
      else begin m_mem[m_cnt] = d; m_cnt++; req = "R2"; end
    end else if (q) begin
      if (m_cnt == 0) begin m_unf = 1'b1; req = "R6"; end
      else begin m_cnt--; req = "R3"; end
    end
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state, with the enable high so R8 applies at count 0
    en = 1'b1;
    #1;
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R6: pop on empty is ignored and flags underflow
    step(1'b0, 1'b1, 16'h0, 1'b1);
    // R4: push with pop on empty stores and flags underflow
    step(1'b1, 1'b1, 16'hA5A5, 1'b1);
    step(1'b0, 1'b1, 16'h0, 1'b1);
    // R2/R8/R10/R9: fill to full with enable on
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, DW'(16'h100 + i), 1'b1);
    // R5: push when full is ignored
    step(1'b1, 1'b0, 16'hDEAD, 1'b1);
    // R4: replace at full, no overflow change
    step(1'b1, 1'b1, 16'hBEEF, 1'b1);
    // R10: enable off while in upper region
    step(1'b0, 1'b0, 16'h0, 1'b0);
    // R3: drain, LIFO order
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, 16'h0, (i % 5) != 0);

    // random sweeps biased alternately toward filling and draining
    for (int ph = 0; ph < 12; ph++) begin
      for (int k = 0; k < 250; k++) begin
        int r = int'($urandom_range(0, 99));
        logic p = (ph % 2 == 0) ? (r < 70) : (r < 25);
        logic q = ($urandom_range(0, 99) < ((ph % 2 == 0) ? 30 : 70));
        logic e = ($urandom_range(0, 9) != 0);
        step(p, q, DW'($urandom), e);
      end
    end

    // R11: flags persist until reset, then clear (R1)
    step(1'b0, 1'b0, 16'h0, 1'b1);
    rst_n = 1'b0;
    m_cnt = 0; m_ovf = 1'b0; m_unf = 1'b0;
    #1;
    check_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule